// File: doc/BRIEF.md
# Electronic Shutter Pulse Sequencer

This block schedules the substrate discharge pulses that clear the photosites of an image sensor before exposure. It runs from a one-cycle field strobe and a one-cycle line strobe. From a set of shutter fields it decides on which lines of which field a discharge pulse is enabled. The fields are the shutter enable, a field count for long exposures, a hold-line count and a pulse-field selector. It also drives a level that is high while the sensor is integrating, and a flag that tells the register interface not to reload the shutter fields while a multi-field exposure is still running.

The shutter fields are sampled only at a field strobe that starts a new sequence. A sequence is one field long when the shutter is stopped or the field count is zero. With a field count N greater than zero, the sequence is N+1 fields long and only one of those fields carries pulses. Pulses run from the first line of that field and stop when the hold-line count plus one lines remain before the field ends. The exposure length is therefore set by whole fields plus a fraction of a field in lines.

Top module: `sub_shutter_seq`

## Requirements
- R1: After reset, `subEn`, `expOut` and `loadInhibit` are low.
- R2: The shutter fields are sampled only at a field strobe where no sequence is running (shutter stopped, or the last field of the sequence just ended); values presented at any other time have no effect on the outputs of the running sequence.
- R3: With the sampled shutter enable at 0, `subEn` stays low for the whole field and `expOut` is high from the sampling field strobe onwards.
- R4: In the pulse field, lines are numbered 0, 1, 2... by line strobes after the field strobe. `subEn` is high on line k exactly when k + HOLD + 1 < `linesPerField`, where HOLD is bits 10:0 of `shdIn` (bit 11 is ignored). When HOLD + 1 >= `linesPerField`, no line carries a pulse.
- R5: With the field count at 0, every field is a new sequence and carries pulses.
- R6: With field count N > 0, the sequence spans N+1 fields numbered 0..N, and pulses appear only in field min(`splIn`, N).
- R7: `loadInhibit` rises at the field strobe that starts a sequence with N > 0, stays high through all N+1 fields, and falls only at the field strobe that ends the last one (unless a new such sequence starts there).
- R8: `expOut` falls at a sequence-start field strobe when that sequence will produce pulses and rises at the line strobe where `subEn` drops after the last pulse line; with no pulses in the sequence it is high throughout.
- R9: `subEn` changes only in the cycle after a line strobe. A line strobe in the same cycle as a field strobe is ignored, and the field strobe restarts the line count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| vdStb | input | 1 | Field start strobe, one cycle |
| hdStb | input | 1 | Line start strobe, one cycle |
| linesPerField | input | 12 | Number of lines in a field |
| smdIn | input | 1 | Shutter enable field |
| svdIn | input | 10 | Extra field count for low-speed exposure |
| shdIn | input | 12 | Hold-line count; bit 11 unused |
| splIn | input | 10 | Index of the field carrying pulses |
| subEn | output | 1 | Discharge pulse enable for the current line |
| loadInhibit | output | 1 | Shutter register reload blocked |
| expOut | output | 1 | High while exposing |

## Verification
Every output is a single register. A field strobe therefore shows up in `loadInhibit` and in a falling `expOut` one clock later, and a line strobe shows up in `subEn` and a rising `expOut` one clock later. The bench drives inputs and compares on the falling edge. On each rising edge its reference model advances from the same inputs, so every compare falls half a cycle after the edge that made the change. The directed checks count the pulse lines of each field after that field's last line strobe has settled. They check the inhibit flag one cycle after the field strobe that should set or clear it.

// File: rtl/shutter_seq_pkg.sv
package shutter_seq_pkg;
  typedef struct packed {
    logic seqStart;
    logic fieldStart;
    logic lineStart;
    logic subField;
  } seqStrobes_t;
endpackage

// File: rtl/shutter_seq_ctrl.sv
module shutter_seq_ctrl
  import shutter_seq_pkg::*;
#(
  parameter int FIELD_W = 10,
  parameter int SHD_W   = 12
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               vdStb,
  input  logic               hdStb,
  input  logic               smdIn,
  input  logic [FIELD_W-1:0] svdIn,
  input  logic [FIELD_W-1:0] splIn,
  input  logic [SHD_W-1:0]   shdIn,
  output seqStrobes_t        strobes,
  output logic [SHD_W-2:0]   actShd,
  output logic               loadInhibit
);
  logic               actSmd;
  logic [FIELD_W-1:0] actSvd;
  logic [FIELD_W-1:0] actSpl;
  logic [FIELD_W-1:0] fieldCnt;
  logic [FIELD_W-1:0] pulseField;
  logic               seqDone;

  // a sequence is over when the shutter is stopped or its last field ran
  assign seqDone    = !actSmd || (fieldCnt == actSvd);
  assign pulseField = (actSpl > actSvd) ? actSvd : actSpl;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      actSmd      <= 1'b0;
      actSvd      <= '0;
      actSpl      <= '0;
      actShd      <= '0;
      fieldCnt    <= '0;
      loadInhibit <= 1'b0;
    end else if (vdStb) begin
      if (seqDone) begin
        actSmd      <= smdIn;
        actSvd      <= svdIn;
        actSpl      <= splIn;
        actShd      <= shdIn[SHD_W-2:0];
        fieldCnt    <= '0;
        loadInhibit <= smdIn && (svdIn != '0);
      end else begin
        fieldCnt <= fieldCnt + 1'b1;
      end
    end
  end

  always_comb begin
    strobes.seqStart   = vdStb && seqDone;
    strobes.fieldStart = vdStb;
    strobes.lineStart  = hdStb && !vdStb;
    strobes.subField   = actSmd && (fieldCnt == pulseField);
  end
endmodule

// File: rtl/shutter_seq_datapath.sv
module shutter_seq_datapath
  import shutter_seq_pkg::*;
#(
  parameter int LINE_W = 12,
  parameter int SHD_W  = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobes_t       strobes,
  input  logic [LINE_W-1:0] linesPerField,
  input  logic              smdIn,
  input  logic [SHD_W-1:0]  shdIn,
  input  logic [SHD_W-2:0]  actShd,
  output logic              subEn,
  output logic              expOut
);
  localparam int SUM_W = LINE_W + 2;
  localparam logic [LINE_W-1:0] LINE_MAX = '1;

  logic [LINE_W-1:0] lineCnt;
  logic [SUM_W-1:0]  lineLimit;
  logic [SUM_W-1:0]  curSum;
  logic [SUM_W-1:0]  newHoldSum;
  logic              subWanted;
  logic              seqPulses;

  assign lineLimit  = SUM_W'(linesPerField);
  assign curSum     = SUM_W'(lineCnt) + SUM_W'(actShd) + SUM_W'(1);
  assign newHoldSum = SUM_W'(shdIn[SHD_W-2:0]) + SUM_W'(1);
  assign subWanted  = strobes.subField && (curSum < lineLimit);
  assign seqPulses  = smdIn && (newHoldSum < lineLimit);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lineCnt <= '0;
      subEn   <= 1'b0;
      expOut  <= 1'b0;
    end else if (strobes.fieldStart) begin
      lineCnt <= '0;
      if (strobes.seqStart) expOut <= !seqPulses;
    end else if (strobes.lineStart) begin
      if (lineCnt != LINE_MAX) lineCnt <= lineCnt + 1'b1;
      if (subEn && !subWanted) expOut <= 1'b1;
      subEn <= subWanted;
    end
  end
endmodule

// File: rtl/sub_shutter_seq.sv
module sub_shutter_seq
  import shutter_seq_pkg::*;
#(
  parameter int FIELD_W = 10,
  parameter int LINE_W  = 12,
  parameter int SHD_W   = 12
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               vdStb,
  input  logic               hdStb,
  input  logic [LINE_W-1:0]  linesPerField,
  input  logic               smdIn,
  input  logic [FIELD_W-1:0] svdIn,
  input  logic [SHD_W-1:0]   shdIn,
  input  logic [FIELD_W-1:0] splIn,
  output logic               subEn,
  output logic               loadInhibit,
  output logic               expOut
);
  seqStrobes_t      strobes;
  logic [SHD_W-2:0] actShd;

  shutter_seq_ctrl #(.FIELD_W(FIELD_W), .SHD_W(SHD_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .vdStb(vdStb), .hdStb(hdStb),
    .smdIn(smdIn), .svdIn(svdIn), .splIn(splIn), .shdIn(shdIn),
    .strobes(strobes), .actShd(actShd), .loadInhibit(loadInhibit)
  );

  shutter_seq_datapath #(.LINE_W(LINE_W), .SHD_W(SHD_W)) dp_i (
    .clk(clk), .rstN(rstN), .strobes(strobes),
    .linesPerField(linesPerField), .smdIn(smdIn), .shdIn(shdIn),
    .actShd(actShd), .subEn(subEn), .expOut(expOut)
  );
endmodule

// File: rtl/shutter_seq_chk.sv
module shutter_seq_chk #(
  parameter int FIELD_W = 10
) (
  input logic               clk,
  input logic               rstN,
  input logic               vdStb,
  input logic               hdStb,
  input logic               smdIn,
  input logic [FIELD_W-1:0] svdIn,
  input logic               subEn,
  input logic               loadInhibit,
  input logic               expOut
);
  AST_SUB_AT_LINE_EDGE: assert property (@(posedge clk) disable iff (!rstN)
    (subEn != $past(subEn)) |-> ($past(hdStb) && !$past(vdStb))); // R9

  AST_INHIBIT_AT_FIELD_EDGE: assert property (@(posedge clk) disable iff (!rstN)
    (loadInhibit != $past(loadInhibit)) |-> $past(vdStb)); // R7

  AST_INHIBIT_RISE_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(loadInhibit) |-> $past(smdIn && (svdIn != '0))); // R7

  AST_EXP_FALL_AT_FIELD: assert property (@(posedge clk) disable iff (!rstN)
    $fell(expOut) |-> $past(vdStb)); // R8

  AST_EXP_RISE_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(expOut) |-> ($past(vdStb) || $fell(subEn))); // R8
endmodule

bind sub_shutter_seq shutter_seq_chk #(.FIELD_W(FIELD_W)) chk_i (
  .clk(clk), .rstN(rstN), .vdStb(vdStb), .hdStb(hdStb), .smdIn(smdIn),
  .svdIn(svdIn), .subEn(subEn), .loadInhibit(loadInhibit), .expOut(expOut)
);

// File: tb/sub_shutter_seq_tb.sv
`timescale 1ns/1ps
module sub_shutter_seq_tb_top;
  localparam int LPF = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        vdStb = 1'b0;
  logic        hdStb = 1'b0;
  logic [11:0] linesPerField = 12'(LPF);
  logic        smdIn = 1'b0;
  logic [9:0]  svdIn = '0;
  logic [11:0] shdIn = '0;
  logic [9:0]  splIn = '0;
  logic        subEn, loadInhibit, expOut;

  int checks = 0;
  int failures = 0;
  string curReq = "R1";
  bit done = 1'b0;

  always #2 clk = ~clk;

  sub_shutter_seq dut_i (
    .clk(clk), .rstN(rstN), .vdStb(vdStb), .hdStb(hdStb),
    .linesPerField(linesPerField), .smdIn(smdIn), .svdIn(svdIn),
    .shdIn(shdIn), .splIn(splIn), .subEn(subEn),
    .loadInhibit(loadInhibit), .expOut(expOut)
  );

  // behavioural reference model
  int  mSmd = 0, mSvd = 0, mShd = 0, mSpl = 0, mField = 0, mLine = 0;
  bit  mSub = 0, mExp = 0, mInh = 0;

  always @(posedge clk) begin
    if (!rstN) begin
      mSmd = 0; mSvd = 0; mShd = 0; mSpl = 0; mField = 0; mLine = 0;
      mSub = 0; mExp = 0; mInh = 0;
    end else if (vdStb) begin
      if (mSmd == 0 || mField == mSvd) begin
        mSmd = int'(smdIn); mSvd = int'(svdIn); mShd = int'(shdIn) % 2048;
        mSpl = int'(splIn); mField = 0;
        mInh = (smdIn && svdIn != 0);
        mExp = !(smdIn && (mShd + 1 < int'(linesPerField)));
      end else begin
        mField++;
      end
      mLine = 0;
    end else if (hdStb) begin
      int sel;
      bit want;
      sel = (mSpl > mSvd) ? mSvd : mSpl;
      want = (mSmd != 0) && (mField == sel) && (mLine + mShd + 1 < int'(linesPerField));
      if (mSub && !want) mExp = 1;
      mSub = want;
      mLine++;
    end
  end

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rstN && !done) begin
      check(curReq, "subEn", int'(subEn), int'(mSub));
      check(curReq, "expOut", int'(expOut), int'(mExp));
      check(curReq, "loadInhibit", int'(loadInhibit), int'(mInh));
    end
  end

  // one field: field strobe then LPF line strobes; returns pulse lines seen
  task automatic runField(output int pulses, input bit overlap = 1'b0);
    pulses = 0;
    @(negedge clk); vdStb = 1'b1; hdStb = overlap;
    @(negedge clk); vdStb = 1'b0; hdStb = 1'b0;
    for (int i = 0; i < LPF; i++) begin
      repeat (3) @(negedge clk);
      hdStb = 1'b1;
      @(negedge clk); hdStb = 1'b0;
      if (subEn) pulses++;
    end
  endtask

  initial begin
    int n;
    repeat (3) @(negedge clk);
    check("R1", "reset subEn", int'(subEn), 0);
    check("R1", "reset expOut", int'(expOut), 0);
    check("R1", "reset loadInhibit", int'(loadInhibit), 0);
    rstN = 1'b1;

    curReq = "R3"; smdIn = 0; shdIn = 12'd2;
    runField(n); check("R3", "stopped pulses", n, 0);
    check("R3", "stopped exp", int'(expOut), 1);

    curReq = "R5"; smdIn = 1; svdIn = 0; shdIn = 12'd3;
    runField(n); check("R5", "high-speed field0 pulses", n, LPF - 4);
    check("R8", "exp high after pulses", int'(expOut), 1);
    runField(n); check("R5", "high-speed field1 pulses", n, LPF - 4);

    curReq = "R4"; shdIn = 12'h803;
    runField(n); check("R4", "bit11 ignored", n, LPF - 4);
    shdIn = 12'd9;
    runField(n); check("R4", "hold equals field", n, 0);
    check("R8", "exp high with no pulse", int'(expOut), 1);
    shdIn = 12'd0;
    runField(n); check("R4", "hold zero", n, LPF - 1);

    curReq = "R6"; svdIn = 10'd2; splIn = 10'd1; shdIn = 12'd5;
    runField(n); check("R6", "lowspeed f0", n, 0);
    check("R7", "inhibit set", int'(loadInhibit), 1);
    check("R8", "exp low before pulses", int'(expOut), 0);
    curReq = "R2"; smdIn = 0; svdIn = 0; splIn = 0;
    runField(n); check("R2", "lowspeed f1 ignores new", n, LPF - 6);
    check("R8", "exp rose after last pulse", int'(expOut), 1);
    runField(n); check("R2", "lowspeed f2", n, 0);
    check("R7", "inhibit held last field", int'(loadInhibit), 1);
    curReq = "R7"; smdIn = 1; svdIn = 10'd2; splIn = 10'd7; shdIn = 12'd2;
    runField(n); check("R6", "clamped f0", n, 0);
    check("R7", "inhibit reloaded", int'(loadInhibit), 1);
    runField(n); check("R6", "clamped f1", n, 0);
    runField(n); check("R6", "clamped f2", n, LPF - 3);
    smdIn = 0;
    runField(n); check("R7", "inhibit cleared", int'(loadInhibit), 0);

    curReq = "R9"; smdIn = 1; svdIn = 0; shdIn = 12'd1;
    runField(n, 1'b1); check("R9", "overlap ignored", n, LPF - 2);

    repeat (4) @(negedge clk);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      done = 1'b1;
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule